// File: doc/BRIEF.md
# Line REI Error Accumulator

This block collects the far-end line error reports that arrive once per frame in the line remote error indication byte. On every frame strobe the byte is decoded into an error count and added to a running counter. A performance-monitor interval pulse copies the running total into a holding register, which is the block's only output, and starts a new interval from zero.

Three configuration inputs shape the accumulation. The first masks the top bit of the byte before it is decoded. The second switches between bit mode, where the decoded count is added, and block mode, where any frame with a nonzero count adds one. The third chooses whether a full running counter stays at its ceiling or wraps around. Byte values above the largest legal count are treated as a report of no errors.

Top module: `rei_err_accum`

## Requirements
- R1: With masking off and bit mode selected, an M1 byte value from 0 to 24 adds exactly that value to the running count.
- R2: Any decoded byte value of 25 or more counts as zero errors and leaves the running count unchanged.
- R3: With the mask input high, bit 7 of the byte is forced to zero before decoding, so 0x85 counts 5 and 0x98 counts 24.
- R4: The running count changes only in a cycle with the frame strobe or the interval pulse high.
- R5: In block mode, each frame whose decoded count is nonzero adds exactly one, and a frame with a zero count adds nothing.
- R6: On the interval pulse, the holding register takes the running total one cycle later and the running count restarts. The holding register is unchanged in any other cycle.
- R7: When a frame strobe and the interval pulse are high in the same cycle, that frame's count is excluded from the total being captured and becomes the first contribution to the new interval.
- R8: With saturation selected, a sum that would exceed 2^CNT_W-1 leaves the running count at 2^CNT_W-1 until the next interval pulse clears it.
- R9: With saturation deselected, the running count wraps modulo 2^CNT_W.
- R10: Synchronous reset clears both the running count and the holding register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse marking a valid M1 byte |
| m1_byte | input | 8 | Received line error report byte |
| pm_tick | input | 1 | Performance-monitor interval pulse |
| cfg_mask_msb | input | 1 | 1: bit 7 is cleared before decoding |
| cfg_block_mode | input | 1 | 1: block mode, 0: bit mode |
| cfg_saturate | input | 1 | 1: saturate at full scale, 0: wrap |
| hold_count | output | CNT_W (18) | Total from the last completed interval |

## Verification
The bench builds the block with CNT_W set to 6. This makes the counter ceiling 63, so both saturation and wrap are reached within a few frames of 24 errors, or 64 block-mode frames. At that width the bench can sweep all 256 byte values across all four mask and mode combinations, with one closed interval per value. The expected totals are computed arithmetically from the decode rule.

// File: rtl/rei_pkg.sv
package rei_pkg;
  // Largest error count a single M1 byte may legally carry
  localparam int unsigned REI_MAX_CODE = 24;

  typedef struct packed {
    logic mask_msb;
    logic block_mode;
    logic saturate;
  } rei_cfg_t;
endpackage

// File: rtl/rei_m1_decode.sv
module rei_m1_decode #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned MAX_CODE = rei_pkg::REI_MAX_CODE,
  parameter int unsigned CODE_W   = $clog2(MAX_CODE + 1)
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              mask_msb,
  input  logic              block_mode,
  output logic [CODE_W-1:0] step
);
  logic [BYTE_W-1:0] masked;
  logic [CODE_W-1:0] code;

  always_comb begin
    masked = byte_in;
    if (mask_msb) masked[BYTE_W-1] = 1'b0;
    if (masked <= BYTE_W'(MAX_CODE)) code = masked[CODE_W-1:0];
    else                             code = '0;
    if (block_mode) step = CODE_W'(code != '0);
    else            step = code;
  end
endmodule

// File: rtl/rei_run_counter.sv
module rei_run_counter #(
  parameter int unsigned CNT_W  = 18,
  parameter int unsigned STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_en,
  input  logic [STEP_W-1:0] step,
  input  logic              restart,
  input  logic              saturate,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, count} + (CNT_W+1)'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (restart) begin
      // a frame arriving with the interval pulse opens the new interval
      count <= add_en ? CNT_W'(step) : '0;
    end else if (add_en) begin
      if (sum[CNT_W] && saturate) count <= '1;
      else                        count <= sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rei_err_accum.sv
module rei_err_accum #(
  parameter int unsigned CNT_W  = 18,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] m1_byte,
  input  logic              pm_tick,
  input  logic              cfg_mask_msb,
  input  logic              cfg_block_mode,
  input  logic              cfg_saturate,
  output logic [CNT_W-1:0]  hold_count
);
  import rei_pkg::*;

  localparam int unsigned STEP_W = $clog2(REI_MAX_CODE + 1);

  rei_cfg_t          cfg;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  run_cnt;

  assign cfg = '{mask_msb: cfg_mask_msb, block_mode: cfg_block_mode,
                 saturate: cfg_saturate};

  rei_m1_decode #(
    .BYTE_W  (BYTE_W),
    .MAX_CODE(REI_MAX_CODE),
    .CODE_W  (STEP_W)
  ) u_dec (
    .byte_in   (m1_byte),
    .mask_msb  (cfg.mask_msb),
    .block_mode(cfg.block_mode),
    .step      (step)
  );

  rei_run_counter #(
    .CNT_W (CNT_W),
    .STEP_W(STEP_W)
  ) u_run (
    .clk     (clk),
    .rst     (rst),
    .add_en  (frame_stb),
    .step    (step),
    .restart (pm_tick),
    .saturate(cfg.saturate),
    .count   (run_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)          hold_count <= '0;
    else if (pm_tick) hold_count <= run_cnt;
  end
endmodule

// File: rtl/rei_accum_chk.sv
module rei_accum_chk #(
  parameter int unsigned CNT_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_stb,
  input logic             pm_tick,
  input logic             cfg_saturate,
  input logic             cfg_block_mode,
  input logic [CNT_W-1:0] run_cnt,
  input logic [CNT_W-1:0] hold_count
);
  localparam logic [CNT_W-1:0] FULL = '1;

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (run_cnt == '0) && (hold_count == '0));

  p_hold_steady_r6: assert property (@(posedge clk) disable iff (rst)
    !pm_tick |=> $stable(hold_count));

  p_hold_capture_r6: assert property (@(posedge clk) disable iff (rst)
    pm_tick |=> hold_count == $past(run_cnt));

  p_restart_empty_r7: assert property (@(posedge clk) disable iff (rst)
    pm_tick && !frame_stb |=> run_cnt == '0);

  p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !frame_stb && !pm_tick |=> $stable(run_cnt));

  p_block_step_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_block_mode && frame_stb && !pm_tick && (run_cnt != FULL) |=>
      (run_cnt == $past(run_cnt)) || (run_cnt == CNT_W'($past(run_cnt) + 1'b1)));

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_saturate && (run_cnt == FULL) && !pm_tick |=> run_cnt == FULL);
endmodule

bind rei_err_accum rei_accum_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_stb     (frame_stb),
  .pm_tick       (pm_tick),
  .cfg_saturate  (cfg_saturate),
  .cfg_block_mode(cfg_block_mode),
  .run_cnt       (run_cnt),
  .hold_count    (hold_count)
);

// File: tb/sim_rei_err_accum.sv
module sim_rei_err_accum;
  localparam int unsigned W = 6;
  localparam int unsigned FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_stb = 1'b0;
  logic [7:0]   m1_byte = '0;
  logic         pm_tick = 1'b0;
  logic         cfg_mask_msb = 1'b0;
  logic         cfg_block_mode = 1'b0;
  logic         cfg_saturate = 1'b0;
  logic [W-1:0] hold_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rei_err_accum #(.CNT_W(W), .BYTE_W(8)) u0 (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .m1_byte(m1_byte),
    .pm_tick(pm_tick), .cfg_mask_msb(cfg_mask_msb),
    .cfg_block_mode(cfg_block_mode), .cfg_saturate(cfg_saturate),
    .hold_count(hold_count)
  );

  function automatic int exp_step(int m, bit mask, bit blk);
    int v;
    v = mask ? (m % 128) : m;
    if (v > 24) v = 0;
    if (blk) v = (v != 0) ? 1 : 0;
    return v;
  endfunction

  task automatic check(int exp, string req);
    checks++;
    if (int'(hold_count) != exp) begin
      errors++;
      $display("FAIL %s: hold_count=%0d expected=%0d", req, hold_count, exp);
    end
  endtask

  task automatic frame(int m);
    @(negedge clk);
    frame_stb = 1'b1;
    m1_byte   = 8'(m);
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  // interval pulse, optionally with a frame in the same cycle
  task automatic tick(bit with_frame, int m);
    @(negedge clk);
    pm_tick   = 1'b1;
    frame_stb = with_frame;
    m1_byte   = 8'(m);
    @(negedge clk);
    pm_tick   = 1'b0;
    frame_stb = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(0, "R10 reset");
    rst = 1'b0;
    tick(1'b0, 0);
    check(0, "R10 run cleared by reset");

    // sweep every byte value under each mask/mode pairing (R1 R2 R3 R5)
    for (int mk = 0; mk < 2; mk++) begin
      for (int bk = 0; bk < 2; bk++) begin
        cfg_mask_msb   = mk[0];
        cfg_block_mode = bk[0];
        for (int m = 0; m < 256; m++) begin
          frame(m);
          tick(1'b0, 0);
          if (bk != 0)      check(exp_step(m, mk[0], 1'b1), "R5 block sweep");
          else if (mk != 0) check(exp_step(m, 1'b1, 1'b0), "R3 masked sweep");
          else if (m <= 24) check(m, "R1 legal count");
          else              check(0, "R2 out of range");
        end
      end
    end
    cfg_mask_msb   = 1'b0;
    cfg_block_mode = 1'b0;

    // R3 specific values
    cfg_mask_msb = 1'b1;
    frame(8'h85); frame(8'h98);
    tick(1'b0, 0);
    check(29, "R3 0x85+0x98");
    cfg_mask_msb = 1'b0;

    // R4: no strobe, inputs wiggle -> nothing added
    frame(10);
    @(negedge clk); m1_byte = 8'd20;
    repeat (3) @(negedge clk);
    tick(1'b0, 0);
    check(10, "R4 idle byte ignored");
    tick(1'b0, 0);
    check(0, "R6 empty interval");

    // R6: hold unchanged between pulses
    frame(7); frame(8);
    tick(1'b0, 0);
    frame(3);
    check(15, "R6 hold stable while running");

    // R7: simultaneous strobe and pulse
    tick(1'b1, 11);
    check(3, "R7 capture excludes same-cycle frame");
    tick(1'b0, 0);
    check(11, "R7 frame lands in new interval");

    // R8 saturation, bit mode: 24*3 = 72 > 63
    cfg_saturate = 1'b1;
    frame(24); frame(24); frame(24); frame(5);
    tick(1'b0, 0);
    check(FULL, "R8 saturate bit mode");
    tick(1'b0, 0);
    check(0, "R8 cleared after interval");

    // R9 wrap, bit mode: 72 mod 64 = 8
    cfg_saturate = 1'b0;
    frame(24); frame(24); frame(24);
    tick(1'b0, 0);
    check(8, "R9 wrap bit mode");

    // R9 wrap block mode: 65 frames -> 1
    cfg_block_mode = 1'b1;
    for (int i = 0; i < 65; i++) frame(1);
    tick(1'b0, 0);
    check(1, "R9 wrap block mode");

    // R8 saturate block mode: 70 frames -> 63
    cfg_saturate = 1'b1;
    for (int i = 0; i < 70; i++) frame(200);
    for (int i = 0; i < 70; i++) frame(3);
    tick(1'b0, 0);
    check(FULL, "R8 saturate block mode");

    // R10 reset mid-interval
    frame(4);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(0, "R10 hold cleared");
    tick(1'b0, 0);
    check(0, "R10 run cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule